// File: doc/BRIEF.md
# Microcoded Transfer Sequencer

This block steers a small accelerator from a stored program. It fetches 36-bit instruction words from a synchronous program memory and decodes each one. Then, cycle by cycle, it drives the data-memory port, the one-hot unit select lines, the unit mode and the unit start pulses. The functional units, the data memory and the program memory sit outside the block.

A full operand moves as a fixed number of narrower words, set by the parameter `WORDS_PER_OP`. A value of 4, 2 or 1 suits a memory word of a quarter, a half or the whole of the operand. An internal loop counter repeats every transfer instruction over that many cycles and steps the memory address by one on each cycle. The same counter times wait instructions. While the counter runs, the program memory is not read.

The instruction stream carries nothing secret, so the order of execution depends only on the program. A host pulses `start` and then watches `busy` and `done`.

Top module: `mcode_seq`

## Requirements
- R1: An instruction word has these fields: opcode in bits 35:32, unit index in 31:29, mode in 28:27, first address in 26:18, second address in 17:9 and immediate in 8:0. The opcodes are 0 no-op, 1 read, 2 write, 3 wait, 4 jump and 5 end. Any other opcode behaves as a no-op.
- R2: A read runs for `WORDS_PER_OP` cycles with `dm_rd_en` high. On cycle k (counting from 0) it drives `dm_addr_a` = first address + k and `dm_addr_b` = second address + k, both wrapping modulo 512. During those cycles `unit_sel` has only the bit of the unit index set, and `unit_mode` carries the mode field.
- R3: On the first cycle of a read, `unit_start` equals `unit_sel`. On every other cycle, and for every other opcode, `unit_start` is zero.
- R4: A write runs for `WORDS_PER_OP` cycles with `dm_wr_en` high and `dm_addr_a` = first address + k, wrapping modulo 512. It selects the unit and passes the mode. It raises no start and holds `dm_rd_en` low.
- R5: A wait with immediate N occupies N cycles, or a single cycle when N is 0. A no-op, or an unknown opcode, occupies exactly one cycle. None of these enables the data memory or selects a unit.
- R6: A jump takes one cycle, and the next instruction executed is the one at the immediate address.
- R7: After an end instruction executes, `busy` is low from the next cycle on. In that same next cycle `done` is high, for exactly one cycle.
- R8: A `start` pulse while idle restarts execution at address 0. A `start` while busy has no effect.
- R9: The program memory read has one cycle of latency. The address of the next instruction is presented, with `pm_en` high, only on the last cycle of the current instruction, and `pm_addr` holds steady while a multi-cycle instruction runs.
- R10: After reset, `busy`, `done`, both memory enables, `unit_sel` and `unit_start` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at address 0 (idle only) |
| busy | output | 1 | High while the program runs |
| done | output | 1 | One-cycle pulse after an end instruction |
| pm_en | output | 1 | Program memory read enable |
| pm_addr | output | 9 | Program memory read address |
| pm_rdata | input | 36 | Program memory data, one cycle after the address |
| dm_rd_en | output | 1 | Data memory read enable |
| dm_wr_en | output | 1 | Data memory write enable |
| dm_addr_a | output | 9 | Data memory read address / write address |
| dm_addr_b | output | 9 | Data memory second read address |
| unit_sel | output | N_UNITS | One-hot select of the unit taking part in a transfer |
| unit_mode | output | 2 | Operation mode for the selected unit |
| unit_start | output | N_UNITS | One-hot start pulse for a unit's computation |

## Verification
The bench targets the word address wrapping past 511. A design that carried into a tenth bit, or that stopped early, would write the wrong words. The test also covers a wait of zero and an unknown opcode. Either one, if mishandled, would stall for hundreds of cycles or raise a memory enable, and the end of the run would move.

A jump that is followed by an end at the next address shows whether the fetch really redirects in the jump cycle. A second `start` raised mid-program shows whether the program counter is wrongly reset, which would lengthen the run. The bench checks where the start pulse falls within a read, and tracks the fetch address across the stalled cycles, to find an extra or missing pipeline stage.

// File: rtl/mcode_pkg.sv
package mcode_pkg;

    localparam int OP_W    = 4;
    localparam int UNIT_W  = 3;
    localparam int MODE_W  = 2;
    localparam int ADDR_W  = 9;
    localparam int IMM_W   = 9;
    localparam int INSTR_W = OP_W + UNIT_W + MODE_W + 2 * ADDR_W + IMM_W;
    localparam int LEN_W   = IMM_W + 1;

    localparam logic [OP_W-1:0] OP_NOP   = 4'd0;
    localparam logic [OP_W-1:0] OP_READ  = 4'd1;
    localparam logic [OP_W-1:0] OP_WRITE = 4'd2;
    localparam logic [OP_W-1:0] OP_WAIT  = 4'd3;
    localparam logic [OP_W-1:0] OP_JUMP  = 4'd4;
    localparam logic [OP_W-1:0] OP_END   = 4'd5;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [UNIT_W-1:0] unit;
        logic [MODE_W-1:0] mode;
        logic [ADDR_W-1:0] addr_a;
        logic [ADDR_W-1:0] addr_b;
        logic [IMM_W-1:0]  imm;
    } instr_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_LOOP = 2'd2
    } seq_state_e;

    function automatic logic is_xfer(logic [OP_W-1:0] op);
        return (op == OP_READ) || (op == OP_WRITE);
    endfunction

    // Number of cycles an instruction occupies
    function automatic logic [LEN_W-1:0] op_length(instr_t ins, int unsigned words);
        logic [LEN_W-1:0] len;
        if (is_xfer(ins.op)) begin
            len = LEN_W'(words);
        end else if (ins.op == OP_WAIT && ins.imm != '0) begin
            len = {1'b0, ins.imm};
        end else begin
            len = LEN_W'(1);
        end
        return len;
    endfunction

endpackage

// File: rtl/mcode_fetch.sv
module mcode_fetch
    import mcode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic              advance,
    input  logic              jump_take,
    input  logic [ADDR_W-1:0] jump_tgt,
    output logic              pm_en,
    output logic [ADDR_W-1:0] pm_addr
);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] target;

    always_comb begin
        if (launch) begin
            target = '0;
        end else if (jump_take) begin
            target = jump_tgt;
        end else begin
            target = pc_q + 1'b1;
        end
    end

    assign pm_en   = launch | advance;
    assign pm_addr = target;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (pm_en) begin
            pc_q <= target;
        end
    end

    // R8: a launch always fetches address zero
    a_r8_launch_zero: assert property (@(posedge clk) disable iff (rst)
        launch |-> (pm_en && pm_addr == '0));

endmodule

// File: rtl/mcode_loop.sv
module mcode_loop
    import mcode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             run,
    output logic [LEN_W-1:0] widx,
    output logic             last
);

    logic [LEN_W-1:0] remain_q;
    logic [LEN_W-1:0] widx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            widx_q   <= '0;
        end else if (load) begin
            remain_q <= load_len - 1'b1;
            widx_q   <= LEN_W'(1);
        end else if (run) begin
            remain_q <= remain_q - 1'b1;
            widx_q   <= widx_q + 1'b1;
        end
    end

    assign widx = widx_q;
    assign last = (remain_q == LEN_W'(1));

    // R5: the loop never runs with an exhausted count
    a_r5_loop_nonzero: assert property (@(posedge clk) disable iff (rst)
        run |-> (remain_q != '0));

    // R2: the word index steps by one while the loop runs
    a_r2_widx_step: assert property (@(posedge clk) disable iff (rst)
        (run && !last) |=> (widx == $past(widx) + 1'b1));

endmodule

// File: rtl/mcode_xfer.sv
module mcode_xfer
    import mcode_pkg::*;
#(
    parameter int N_UNITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               active,
    input  logic               is_read,
    input  logic               first,
    input  logic [UNIT_W-1:0]  unit,
    input  logic [MODE_W-1:0]  mode,
    input  logic [ADDR_W-1:0]  base_a,
    input  logic [ADDR_W-1:0]  base_b,
    input  logic [LEN_W-1:0]   widx,
    output logic               rd_en,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  addr_a,
    output logic [ADDR_W-1:0]  addr_b,
    output logic [N_UNITS-1:0] sel,
    output logic [MODE_W-1:0]  mode_o,
    output logic [N_UNITS-1:0] start_o
);

    logic [ADDR_W-1:0] step;

    assign step   = ADDR_W'(widx);
    assign rd_en  = active && is_read;
    assign wr_en  = active && !is_read;
    assign addr_a = active ? (base_a + step) : '0;
    assign addr_b = rd_en ? (base_b + step) : '0;
    assign mode_o = active ? mode : '0;

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        assign sel[u]     = active && (unit == UNIT_W'(u));
        assign start_o[u] = sel[u] && first && is_read;
    end

    // R2: at most one unit takes part in a transfer
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R3: a start pulse only appears on a read
    a_r3_start_read: assert property (@(posedge clk) disable iff (rst)
        (start_o != '0) |-> (rd_en && start_o == sel));

    // R4: read and write never coincide
    a_r4_rw_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && wr_en));

    // R2: later words of a transfer step the address by one
    a_r2_addr_step: assert property (@(posedge clk) disable iff (rst)
        (active && widx != '0) |-> (addr_a == ADDR_W'($past(addr_a) + 1'b1)));

endmodule

// File: rtl/mcode_seq.sv
module mcode_seq
    import mcode_pkg::*;
#(
    parameter int WORDS_PER_OP = 4,
    parameter int N_UNITS      = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic               done,
    output logic               pm_en,
    output logic [ADDR_W-1:0]  pm_addr,
    input  logic [INSTR_W-1:0] pm_rdata,
    output logic               dm_rd_en,
    output logic               dm_wr_en,
    output logic [ADDR_W-1:0]  dm_addr_a,
    output logic [ADDR_W-1:0]  dm_addr_b,
    output logic [N_UNITS-1:0] unit_sel,
    output logic [MODE_W-1:0]  unit_mode,
    output logic [N_UNITS-1:0] unit_start
);

    seq_state_e       state_q;
    instr_t           ir_q;
    instr_t           cur;
    logic             done_q;
    logic             in_exec;
    logic             in_loop;
    logic [LEN_W-1:0] len;
    logic             loop_last;
    logic [LEN_W-1:0] loop_widx;
    logic             last;
    logic             is_end;
    logic             advance;
    logic             jump_take;
    logic             launch;
    logic             loop_load;
    logic             xfer_active;
    logic [LEN_W-1:0] widx;

    assign in_exec   = (state_q == ST_EXEC);
    assign in_loop   = (state_q == ST_LOOP);
    assign cur       = in_exec ? instr_t'(pm_rdata) : ir_q;
    assign len       = op_length(cur, WORDS_PER_OP);
    assign last      = in_exec ? (len == LEN_W'(1)) : (in_loop && loop_last);
    assign is_end    = in_exec && (cur.op == OP_END);
    assign advance   = (in_exec || in_loop) && last && !is_end;
    assign jump_take = in_exec && (cur.op == OP_JUMP);
    assign launch    = (state_q == ST_IDLE) && start;
    assign loop_load = in_exec && (len != LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ir_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= is_end;
            unique case (state_q)
                ST_IDLE: if (launch) state_q <= ST_EXEC;
                ST_EXEC: begin
                    if (is_end) begin
                        state_q <= ST_IDLE;
                    end else if (loop_load) begin
                        state_q <= ST_LOOP;
                        ir_q    <= cur;
                    end
                end
                ST_LOOP: if (loop_last) state_q <= ST_EXEC;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;

    mcode_fetch u_fetch (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .advance   (advance),
        .jump_take (jump_take),
        .jump_tgt  (cur.imm),
        .pm_en     (pm_en),
        .pm_addr   (pm_addr)
    );

    mcode_loop u_loop (
        .clk      (clk),
        .rst      (rst),
        .load     (loop_load),
        .load_len (len),
        .run      (in_loop),
        .widx     (loop_widx),
        .last     (loop_last)
    );

    assign xfer_active = (in_exec || in_loop) && is_xfer(cur.op);
    assign widx        = in_exec ? '0 : loop_widx;

    mcode_xfer #(.N_UNITS(N_UNITS)) u_xfer (
        .clk     (clk),
        .rst     (rst),
        .active  (xfer_active),
        .is_read (cur.op == OP_READ),
        .first   (in_exec),
        .unit    (cur.unit),
        .mode    (cur.mode),
        .base_a  (cur.addr_a),
        .base_b  (cur.addr_b),
        .widx    (widx),
        .rd_en   (dm_rd_en),
        .wr_en   (dm_wr_en),
        .addr_a  (dm_addr_a),
        .addr_b  (dm_addr_b),
        .sel     (unit_sel),
        .mode_o  (unit_mode),
        .start_o (unit_start)
    );

    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: busy has dropped when done is seen
    a_r7_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: no fetch and a steady fetch address while a loop runs
    a_r9_fetch_hold: assert property (@(posedge clk) disable iff (rst)
        (in_loop && !loop_last) |-> (!pm_en && $stable(pm_addr)));

    // R5: waits leave the data memory alone
    a_r5_wait_silent: assert property (@(posedge clk) disable iff (rst)
        ((in_exec || in_loop) && cur.op == OP_WAIT) |-> (!dm_rd_en && !dm_wr_en));

    // R10: nothing is driven while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!dm_rd_en && !dm_wr_en && unit_sel == '0));

endmodule

// File: tb/mcode_seq_tb_top.sv
module mcode_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        busy, done, pm_en;
    logic [8:0]  pm_addr;
    logic [35:0] pm_rdata;
    logic        dm_rd_en, dm_wr_en;
    logic [8:0]  dm_addr_a, dm_addr_b;
    logic [7:0]  unit_sel, unit_start;
    logic [1:0]  unit_mode;

    logic [35:0] prog [0:511];

    int nchk = 0;
    int nerr = 0;

    int c_rd[0:39], c_wr[0:39], c_a[0:39], c_b[0:39], c_sel[0:39];
    int c_mode[0:39], c_st[0:39], c_busy[0:39], c_done[0:39];
    int c_pe[0:39], c_pa[0:39];

    always #10 clk = ~clk;

    always_ff @(posedge clk) begin
        if (pm_en) pm_rdata <= prog[pm_addr];
    end

    mcode_seq dut_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .busy       (busy),
        .done       (done),
        .pm_en      (pm_en),
        .pm_addr    (pm_addr),
        .pm_rdata   (pm_rdata),
        .dm_rd_en   (dm_rd_en),
        .dm_wr_en   (dm_wr_en),
        .dm_addr_a  (dm_addr_a),
        .dm_addr_b  (dm_addr_b),
        .unit_sel   (unit_sel),
        .unit_mode  (unit_mode),
        .unit_start (unit_start)
    );

    function automatic logic [35:0] enc(int op, int unit, int mode, int a, int b, int imm);
        return {4'(op), 3'(unit), 2'(mode), 9'(a), 9'(b), 9'(imm)};
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Pulse start, then record n cycles; raise start again in cycle restart_at
    task automatic run(int n, int restart_at);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            c_rd[i] = int'(dm_rd_en);   c_wr[i] = int'(dm_wr_en);
            c_a[i] = int'(dm_addr_a);   c_b[i] = int'(dm_addr_b);
            c_sel[i] = int'(unit_sel);  c_mode[i] = int'(unit_mode);
            c_st[i] = int'(unit_start); c_busy[i] = int'(busy);
            c_done[i] = int'(done);     c_pe[i] = int'(pm_en);
            c_pa[i] = int'(pm_addr);
            start = (i == restart_at);
        end
        start = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R10", "busy", int'(busy), 0);
        chk("R10", "done", int'(done), 0);
        chk("R10", "mem enables", int'(dm_rd_en) + int'(dm_wr_en), 0);
        chk("R10", "unit_sel", int'(unit_sel), 0);
        chk("R10", "unit_start", int'(unit_start), 0);
    endtask

    task automatic load_main;
        for (int i = 0; i < 512; i++) prog[i] = '0;
        prog[0] = enc(1, 2, 1, 10, 20, 0);     // read unit 2
        prog[1] = enc(3, 0, 0, 0, 0, 3);       // wait 3
        prog[2] = enc(0, 0, 0, 0, 0, 0);       // nop
        prog[3] = enc(2, 5, 2, 510, 0, 0);     // write unit 5, wraps
        prog[4] = enc(4, 0, 0, 0, 0, 6);       // jump 6
        prog[5] = enc(5, 0, 0, 0, 0, 0);       // end, skipped
        prog[6] = enc(3, 0, 0, 0, 0, 0);       // wait 0
        prog[7] = enc(5, 0, 0, 0, 0, 0);       // end
    endtask

    task automatic t_main;
        load_main();
        run(18, 0);
        // R1 R2: read decoded from the field layout
        chk("R1", "read decoded", c_rd[1], 1);
        chk("R2", "read addr_a word0", c_a[1], 10);
        chk("R2", "read addr_b word0", c_b[1], 20);
        chk("R2", "read addr_a word3", c_a[4], 13);
        chk("R2", "read addr_b word2", c_b[3], 22);
        chk("R2", "read sel", c_sel[2], 4);
        chk("R2", "read mode", c_mode[3], 1);
        chk("R2", "read still on word3", c_rd[4], 1);
        // R3
        chk("R3", "start on first word", c_st[1], 4);
        chk("R3", "no start on word2", c_st[2], 0);
        // R9
        chk("R9", "no fetch mid-read", c_pe[2], 0);
        chk("R9", "fetch addr held", c_pa[3], 1);
        chk("R9", "fetch on last word", c_pe[4], 1);
        chk("R9", "fetch addr last word", c_pa[4], 1);
        // R5 wait 3 in cycles 5..7, nop at 8
        chk("R5", "wait no read", c_rd[5], 0);
        chk("R5", "wait no sel", c_sel[6], 0);
        chk("R5", "wait mode zero", c_mode[5], 0);
        chk("R5", "wait no early fetch", c_pe[6], 0);
        chk("R5", "wait fetch at end", c_pa[7], 2);
        chk("R5", "nop one cycle", c_pa[8], 3);
        // R4 write 9..12 wrapping
        chk("R4", "write en", c_wr[9], 1);
        chk("R4", "write no read", c_rd[10], 0);
        chk("R4", "write addr word0", c_a[9], 510);
        chk("R4", "write addr word1", c_a[10], 511);
        chk("R4", "write addr wrap word2", c_a[11], 0);
        chk("R4", "write addr word3", c_a[12], 1);
        chk("R4", "write sel", c_sel[11], 32);
        chk("R4", "write mode", c_mode[9], 2);
        chk("R4", "write no start", c_st[9], 0);
        chk("R4", "write length", c_wr[13], 0);
        // R6 jump at 13
        chk("R6", "jump target fetched", c_pa[13], 6);
        chk("R6", "jump fetch en", c_pe[13], 1);
        // wait 0 at 14, end at 15
        chk("R5", "wait zero one cycle", c_pa[14], 7);
        chk("R7", "busy during end", c_busy[15], 1);
        chk("R7", "no done early", c_done[15], 0);
        chk("R7", "busy drops", c_busy[16], 0);
        chk("R7", "done pulse", c_done[16], 1);
        chk("R7", "done one cycle", c_done[17], 0);
    endtask

    task automatic t_rerun;
        run(4, 0);
        chk("R8", "restart from address 0 start", c_st[1], 4);
        chk("R8", "restart from address 0 addr", c_a[1], 10);
        chk("R8", "restart busy", c_busy[1], 1);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_ignore;
        for (int i = 0; i < 512; i++) prog[i] = '0;
        prog[0] = enc(15, 3, 3, 5, 6, 0);      // unknown opcode
        prog[1] = enc(3, 0, 0, 0, 0, 5);       // wait 5
        prog[2] = enc(5, 0, 0, 0, 0, 0);       // end
        run(10, 3);
        chk("R5", "unknown opcode no access", c_rd[1] + c_wr[1], 0);
        chk("R5", "unknown opcode no sel", c_sel[1], 0);
        chk("R5", "unknown opcode one cycle", c_pa[1], 1);
        chk("R8", "start while busy ignored", c_pa[6], 2);
        chk("R8", "busy until end", c_busy[7], 1);
        chk("R8", "done timing kept", c_done[8], 1);
        chk("R8", "idle after", c_busy[9], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        t_reset();
        t_main();
        t_rerun();
        t_ignore();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule